// File: doc/BRIEF.md
# Memory Ordering Violation Detector

This block watches the loads of an out-of-order core while they sit in a circular load queue, and reports when one of them has read memory too early. Each load gets an entry at the tail when it is allocated and gives it up at the head when it retires. Once a load has executed, the block keeps its address. When a store later resolves its address, the block searches the queue for younger loads that already read the same location. An external invalidate snoop marks executed loads in the snooped cache block. If an older load then executes to the same location, the younger marked load has observed a stale ordering.

All dependence comparisons use addresses shifted right by a parameter, so locations match at a coarse granule. Snoops match at cache-block granularity. Instruction age comes from sequence tags that carry one extra wrap bit. A squash drops every entry younger than a given tag. When violations are found, the oldest violating load is held behind a sticky flag together with its queue index and tag. A read strobe consumes the flag.

Top module: `mov_detect`

## Requirements
- R1: In the cycle after a reset cycle, `viol_flag` is 0, `viol_idx` is 0, `viol_tag` is 0, and the load queue is empty. The first allocation after reset goes to index 0.
- R2: When a store resolves, a violation is recorded if a valid load has already executed, is younger than the store and matches the store's granule. The flag, the load's queue index and its tag appear on the outputs one cycle after the store event.
- R3: Two addresses match when they are equal after a right shift by `DEP_SHIFT` (default 3). With the default, 0x104 matches 0x100 but 0x108 does not.
- R4: Loads that are older than the store, or that have not executed yet, never produce a violation on a store event.
- R5: A snoop marks each executed valid load whose address, with the low `BLK_BITS` (default 6) cleared, equals the snooped block. When a load executes, a violation is recorded for any younger, marked, executed load in the same granule. With no matching snoop, no violation is recorded.
- R6: When several loads violate in the same cycle, the oldest is recorded. While the flag is set, a new violation replaces the recorded one only if the new load is older.
- R7: The flag stays set until `viol_rd` is pulsed, and the read clears it on the next cycle. If a new violation arrives in the same cycle as the read, the new one is recorded and the flag stays set.
- R8: With `CHECK_LOADS` = 0, a load executing never produces a violation. Store-side checks are unaffected.
- R9: Tags are `TAG_W` bits. Tag a is younger than tag b when (a − b) mod 2^TAG_W is nonzero and below 2^(TAG_W−1). So with 8-bit tags, tag 3 is younger than tag 250.
- R10: A squash invalidates every entry strictly younger than the squash tag. Invalidated entries take no part in any later match, and the squash tag's own entry stays valid.
- R11: Retire frees the head entry, and indices wrap from `LQ_DEPTH`−1 to 0. After wrapping, violations report the wrapped index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_vld | input | 1 | Allocate a load entry at the queue tail |
| alloc_tag | input | TAG_W | Sequence tag of the allocated load |
| retire_vld | input | 1 | Free the entry at the queue head |
| ld_exec_vld | input | 1 | A queued load has executed |
| ld_exec_idx | input | IDX_W | Queue index of the executing load |
| ld_exec_addr | input | ADDR_W | Address read by the executing load |
| st_res_vld | input | 1 | A store has resolved its address |
| st_res_tag | input | TAG_W | Sequence tag of the store |
| st_res_addr | input | ADDR_W | Resolved store address |
| snp_vld | input | 1 | External invalidate snoop |
| snp_addr | input | ADDR_W | Snooped address |
| squash_vld | input | 1 | Squash loads younger than squash_tag |
| squash_tag | input | TAG_W | Squash boundary tag |
| viol_rd | input | 1 | Consume the recorded violator |
| viol_flag | output | 1 | Sticky violation present |
| viol_idx | output | IDX_W | Queue index of the recorded violator |
| viol_tag | output | TAG_W | Sequence tag of the recorded violator |

## Verification
Any per-entry state that goes wrong shows up on the store or load event that touches the entry. Examples are a lost executed bit, a snoop mark that is missing or left over, or an entry that survives a squash. The port either reports a violation it should not report, or misses one, exactly one cycle after that event. A wrong head or tail pointer shows as a wrong `viol_idx` once the queue wraps. A wrong age comparison shows as the wrong tag being held when two loads violate together or one after another.

// File: rtl/mov_pkg.sv
package mov_pkg;

  // Modular age test: a is younger than b when the wrapped difference is
  // nonzero and lies in the lower half of the tag space.
  function automatic logic tag_younger(input logic [31:0] a,
                                       input logic [31:0] b,
                                       input int unsigned w);
    logic [31:0] m;
    logic [31:0] d;
    m = (32'd1 << w) - 32'd1;
    d = (a - b) & m;
    return (d != 32'd0) && (((d >> (w - 1)) & 32'd1) == 32'd0);
  endfunction

endpackage

// File: rtl/mov_lq_state.sv
module mov_lq_state #(
  parameter int LQ_DEPTH = 8,
  parameter int ADDR_W   = 32,
  parameter int TAG_W    = 8,
  parameter int BLK_BITS = 6,
  localparam int IDX_W   = (LQ_DEPTH > 1) ? $clog2(LQ_DEPTH) : 1,
  localparam int CNT_W   = $clog2(LQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_vld,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              retire_vld,
  input  logic              ld_exec_vld,
  input  logic [IDX_W-1:0]  ld_exec_idx,
  input  logic [ADDR_W-1:0] ld_exec_addr,
  input  logic              snp_vld,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              squash_vld,
  input  logic [TAG_W-1:0]  squash_tag,
  output logic [LQ_DEPTH-1:0] ent_vld,
  output logic [LQ_DEPTH-1:0] ent_exe,
  output logic [LQ_DEPTH-1:0] ent_snp,
  output logic [TAG_W-1:0]  ent_tag  [LQ_DEPTH],
  output logic [ADDR_W-1:0] ent_addr [LQ_DEPTH]
);
  import mov_pkg::*;

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic             do_ret, do_alloc;

  function automatic logic [IDX_W-1:0] ptr_next(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(LQ_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_ret   = retire_vld && (count_q != '0);
  assign do_alloc = alloc_vld && ((count_q != CNT_W'(LQ_DEPTH)) || do_ret);

  // Pointers and occupancy
  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_ret)   head_q <= ptr_next(head_q);
      if (do_alloc) tail_q <= ptr_next(tail_q);
      case ({do_alloc, do_ret})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // Per-entry status bits
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
      ent_exe <= '0;
      ent_snp <= '0;
    end else begin
      for (int i = 0; i < LQ_DEPTH; i++) begin
        if (snp_vld && ent_vld[i] && ent_exe[i] &&
            ((ent_addr[i] >> BLK_BITS) == (snp_addr >> BLK_BITS)))
          ent_snp[i] <= 1'b1;
        if (squash_vld && ent_vld[i] &&
            tag_younger(32'(ent_tag[i]), 32'(squash_tag), TAG_W))
          ent_vld[i] <= 1'b0;
      end
      if (do_ret) ent_vld[head_q] <= 1'b0;
      if (do_alloc) begin
        ent_vld[tail_q] <= 1'b1;
        ent_exe[tail_q] <= 1'b0;
        ent_snp[tail_q] <= 1'b0;
      end
      if (ld_exec_vld) begin
        ent_exe[ld_exec_idx] <= 1'b1;
        ent_snp[ld_exec_idx] <= 1'b0;
      end
    end
  end

  // Payload arrays: no reset, single write port each
  always_ff @(posedge clk) begin
    if (do_alloc) ent_tag[tail_q] <= alloc_tag;
  end

  always_ff @(posedge clk) begin
    if (ld_exec_vld) ent_addr[ld_exec_idx] <= ld_exec_addr;
  end

endmodule

// File: rtl/mov_hit_scan.sv
module mov_hit_scan #(
  parameter int LQ_DEPTH    = 8,
  parameter int ADDR_W      = 32,
  parameter int TAG_W       = 8,
  parameter int DEP_SHIFT   = 3,
  parameter int CHECK_LOADS = 1
) (
  input  logic [LQ_DEPTH-1:0] ent_vld,
  input  logic [LQ_DEPTH-1:0] ent_exe,
  input  logic [LQ_DEPTH-1:0] ent_snp,
  input  logic [TAG_W-1:0]    ent_tag  [LQ_DEPTH],
  input  logic [ADDR_W-1:0]   ent_addr [LQ_DEPTH],
  input  logic                st_vld,
  input  logic [TAG_W-1:0]    st_tag,
  input  logic [ADDR_W-1:0]   st_addr,
  input  logic                ld_vld,
  input  logic [TAG_W-1:0]    ld_tag,
  input  logic [ADDR_W-1:0]   ld_addr,
  output logic [LQ_DEPTH-1:0] hit
);
  import mov_pkg::*;

  localparam logic LD_EN = (CHECK_LOADS != 0);

  logic [LQ_DEPTH-1:0] st_hit, ld_hit;

  for (genvar g = 0; g < LQ_DEPTH; g++) begin : g_ent
    logic live, st_gran, ld_gran;
    assign live    = ent_vld[g] && ent_exe[g];
    assign st_gran = (ent_addr[g] >> DEP_SHIFT) == (st_addr >> DEP_SHIFT);
    assign ld_gran = (ent_addr[g] >> DEP_SHIFT) == (ld_addr >> DEP_SHIFT);
    assign st_hit[g] = st_vld && live && st_gran &&
                       tag_younger(32'(ent_tag[g]), 32'(st_tag), TAG_W);
    assign ld_hit[g] = LD_EN && ld_vld && live && ent_snp[g] && ld_gran &&
                       tag_younger(32'(ent_tag[g]), 32'(ld_tag), TAG_W);
  end

  assign hit = st_hit | ld_hit;

endmodule

// File: rtl/mov_oldest_pick.sv
module mov_oldest_pick #(
  parameter int LQ_DEPTH = 8,
  parameter int TAG_W    = 8,
  localparam int IDX_W   = (LQ_DEPTH > 1) ? $clog2(LQ_DEPTH) : 1
) (
  input  logic [LQ_DEPTH-1:0] hit,
  input  logic [TAG_W-1:0]    tags [LQ_DEPTH],
  output logic                found,
  output logic [IDX_W-1:0]    idx,
  output logic [TAG_W-1:0]    tag
);
  import mov_pkg::*;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    tag   = '0;
    for (int i = 0; i < LQ_DEPTH; i++) begin
      if (hit[i] && (!found || tag_younger(32'(tag), 32'(tags[i]), TAG_W))) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        tag   = tags[i];
      end
    end
  end

endmodule

// File: rtl/mov_detect.sv
module mov_detect #(
  parameter int LQ_DEPTH    = 8,
  parameter int ADDR_W      = 32,
  parameter int TAG_W       = 8,
  parameter int DEP_SHIFT   = 3,
  parameter int BLK_BITS    = 6,
  parameter int CHECK_LOADS = 1,
  localparam int IDX_W      = (LQ_DEPTH > 1) ? $clog2(LQ_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_vld,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              retire_vld,
  input  logic              ld_exec_vld,
  input  logic [IDX_W-1:0]  ld_exec_idx,
  input  logic [ADDR_W-1:0] ld_exec_addr,
  input  logic              st_res_vld,
  input  logic [TAG_W-1:0]  st_res_tag,
  input  logic [ADDR_W-1:0] st_res_addr,
  input  logic              snp_vld,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              squash_vld,
  input  logic [TAG_W-1:0]  squash_tag,
  input  logic              viol_rd,
  output logic              viol_flag,
  output logic [IDX_W-1:0]  viol_idx,
  output logic [TAG_W-1:0]  viol_tag
);
  import mov_pkg::*;

  logic [LQ_DEPTH-1:0] ent_vld, ent_exe, ent_snp, hit_vec;
  logic [TAG_W-1:0]    ent_tag  [LQ_DEPTH];
  logic [ADDR_W-1:0]   ent_addr [LQ_DEPTH];
  logic                pick_found;
  logic [IDX_W-1:0]    pick_idx;
  logic [TAG_W-1:0]    pick_tag;
  logic [TAG_W-1:0]    exec_tag;
  logic                take_new;

  mov_lq_state #(
    .LQ_DEPTH(LQ_DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .BLK_BITS(BLK_BITS)
  ) u_state (
    .clk(clk), .rst(rst),
    .alloc_vld(alloc_vld), .alloc_tag(alloc_tag), .retire_vld(retire_vld),
    .ld_exec_vld(ld_exec_vld), .ld_exec_idx(ld_exec_idx),
    .ld_exec_addr(ld_exec_addr), .snp_vld(snp_vld), .snp_addr(snp_addr),
    .squash_vld(squash_vld), .squash_tag(squash_tag),
    .ent_vld(ent_vld), .ent_exe(ent_exe), .ent_snp(ent_snp),
    .ent_tag(ent_tag), .ent_addr(ent_addr)
  );

  assign exec_tag = ent_tag[ld_exec_idx];

  mov_hit_scan #(
    .LQ_DEPTH(LQ_DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W),
    .DEP_SHIFT(DEP_SHIFT), .CHECK_LOADS(CHECK_LOADS)
  ) u_scan (
    .ent_vld(ent_vld), .ent_exe(ent_exe), .ent_snp(ent_snp),
    .ent_tag(ent_tag), .ent_addr(ent_addr),
    .st_vld(st_res_vld), .st_tag(st_res_tag), .st_addr(st_res_addr),
    .ld_vld(ld_exec_vld), .ld_tag(exec_tag), .ld_addr(ld_exec_addr),
    .hit(hit_vec)
  );

  mov_oldest_pick #(.LQ_DEPTH(LQ_DEPTH), .TAG_W(TAG_W)) u_pick (
    .hit(hit_vec), .tags(ent_tag),
    .found(pick_found), .idx(pick_idx), .tag(pick_tag)
  );

  // A fresh violator is taken when nothing is held, when the held one is
  // being consumed, or when the fresh one is older than the held one.
  assign take_new = pick_found &&
                    (!viol_flag || viol_rd ||
                     tag_younger(32'(viol_tag), 32'(pick_tag), TAG_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_flag <= 1'b0;
      viol_idx  <= '0;
      viol_tag  <= '0;
    end else if (take_new) begin
      viol_flag <= 1'b1;
      viol_idx  <= pick_idx;
      viol_tag  <= pick_tag;
    end else if (viol_rd) begin
      viol_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/mov_detect_chk.sv
module mov_detect_chk #(
  parameter int TAG_W       = 8,
  parameter int CHECK_LOADS = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             viol_flag,
  input logic             viol_rd,
  input logic [TAG_W-1:0] viol_tag,
  input logic             st_res_vld,
  input logic             ld_exec_vld,
  input logic             pick_found
);
  import mov_pkg::*;

  // R1: flag low right after a reset cycle
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> !viol_flag);

  // R2: a raised flag is always caused by a store or load event
  assert_rise_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(viol_flag) |-> ($past(st_res_vld) || $past(ld_exec_vld)));

  // R7: sticky until read
  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    viol_flag && !viol_rd |=> viol_flag);

  // R7: read with no fresh violation clears the flag
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
    viol_flag && viol_rd && !pick_found |=> !viol_flag);

  // R6: while held and unread, the recorded tag never gets younger
  assert_oldest_kept_R6: assert property (@(posedge clk) disable iff (rst)
    viol_flag && !viol_rd |=>
      !tag_younger(32'(viol_tag), 32'($past(viol_tag)), TAG_W));

  if (CHECK_LOADS == 0) begin : g_noload
    // R8: only stores can raise the flag
    assert_store_only_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(viol_flag) |-> $past(st_res_vld));
  end

endmodule

bind mov_detect mov_detect_chk #(.TAG_W(TAG_W), .CHECK_LOADS(CHECK_LOADS)) u_chk (
  .clk(clk), .rst(rst), .viol_flag(viol_flag), .viol_rd(viol_rd),
  .viol_tag(viol_tag), .st_res_vld(st_res_vld), .ld_exec_vld(ld_exec_vld),
  .pick_found(pick_found)
);

// File: tb/sim_mov_detect.sv
`timescale 1ns/1ps
module sim_mov_detect;

  logic        clk = 1'b0;
  logic        rst;
  logic        alloc_vld, retire_vld, ld_exec_vld, st_res_vld;
  logic        snp_vld, squash_vld, viol_rd;
  logic [7:0]  alloc_tag, st_res_tag, squash_tag;
  logic [2:0]  ld_exec_idx;
  logic [31:0] ld_exec_addr, st_res_addr, snp_addr;
  logic        f0, f1;
  logic [2:0]  i0, i1;
  logic [7:0]  t0, t1;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mov_detect u0 (
    .clk(clk), .rst(rst), .alloc_vld(alloc_vld), .alloc_tag(alloc_tag),
    .retire_vld(retire_vld), .ld_exec_vld(ld_exec_vld),
    .ld_exec_idx(ld_exec_idx), .ld_exec_addr(ld_exec_addr),
    .st_res_vld(st_res_vld), .st_res_tag(st_res_tag),
    .st_res_addr(st_res_addr), .snp_vld(snp_vld), .snp_addr(snp_addr),
    .squash_vld(squash_vld), .squash_tag(squash_tag), .viol_rd(viol_rd),
    .viol_flag(f0), .viol_idx(i0), .viol_tag(t0)
  );

  mov_detect #(.CHECK_LOADS(0)) u1 (
    .clk(clk), .rst(rst), .alloc_vld(alloc_vld), .alloc_tag(alloc_tag),
    .retire_vld(retire_vld), .ld_exec_vld(ld_exec_vld),
    .ld_exec_idx(ld_exec_idx), .ld_exec_addr(ld_exec_addr),
    .st_res_vld(st_res_vld), .st_res_tag(st_res_tag),
    .st_res_addr(st_res_addr), .snp_vld(snp_vld), .snp_addr(snp_addr),
    .squash_vld(squash_vld), .squash_tag(squash_tag), .viol_rd(viol_rd),
    .viol_flag(f1), .viol_idx(i1), .viol_tag(t1)
  );

  typedef struct packed {
    logic [31:0] ld_addr;
    logic [31:0] st_addr;
    logic [7:0]  ld_tag;
    logic [7:0]  st_tag;
    logic        exp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'h100, 32'h100, 8'd5,   8'd2,   1'b1},  // R2 exact match
    '{32'h104, 32'h100, 8'd5,   8'd2,   1'b1},  // R3 same granule
    '{32'h108, 32'h100, 8'd5,   8'd2,   1'b0},  // R3 next granule
    '{32'h100, 32'h100, 8'd2,   8'd5,   1'b0},  // R4 older load
    '{32'h100, 32'h107, 8'd3,   8'd250, 1'b1},  // R9 younger across wrap
    '{32'h100, 32'h100, 8'd250, 8'd3,   1'b0}   // R9 older across wrap
  };

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", what, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    alloc_vld = 0; retire_vld = 0; ld_exec_vld = 0; st_res_vld = 0;
    snp_vld = 0; squash_vld = 0; viol_rd = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc();
    rst = 1'b0;
  endtask

  task automatic alloc(input logic [7:0] t);
    alloc_vld = 1; alloc_tag = t; cyc();
  endtask

  task automatic lexec(input logic [2:0] idx, input logic [31:0] a);
    ld_exec_vld = 1; ld_exec_idx = idx; ld_exec_addr = a; cyc();
  endtask

  task automatic store(input logic [7:0] t, input logic [31:0] a);
    st_res_vld = 1; st_res_tag = t; st_res_addr = a; cyc();
  endtask

  task automatic snoop(input logic [31:0] a);
    snp_vld = 1; snp_addr = a; cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; alloc_tag = 0; st_res_tag = 0; squash_tag = 0;
    ld_exec_idx = 0; ld_exec_addr = 0; st_res_addr = 0; snp_addr = 0;
    @(negedge clk);
    cyc();
    do_reset();
    // R1 reset state
    chk("R1 flag", 32'(f0), 0);
    chk("R1 idx", 32'(i0), 0);
    chk("R1 tag", 32'(t0), 0);

    // Table: one load, one store, checked one cycle after the store
    for (int k = 0; k < 6; k++) begin
      do_reset();
      alloc(VEC[k].ld_tag);
      lexec(3'd0, VEC[k].ld_addr);
      store(VEC[k].st_tag, VEC[k].st_addr);
      chk($sformatf("table case %0d (R2 R3 R4 R9) flag", k), 32'(f0), 32'(VEC[k].exp));
      if (VEC[k].exp) begin
        chk($sformatf("table case %0d R2 idx", k), 32'(i0), 0);
        chk($sformatf("table case %0d R2 tag", k), 32'(t0), 32'(VEC[k].ld_tag));
      end
    end

    // R4 store before the load executes
    do_reset();
    alloc(8'd7);
    store(8'd6, 32'h100);
    chk("R4 unexecuted load", 32'(f0), 0);

    // R5 snoop then older load: younger load flagged; R8 u1 silent
    do_reset();
    alloc(8'd10); alloc(8'd11);
    lexec(3'd1, 32'h240);
    snoop(32'h27F);
    lexec(3'd0, 32'h244);
    chk("R5 flag", 32'(f0), 1);
    chk("R5 idx", 32'(i0), 1);
    chk("R5 tag", 32'(t0), 11);
    chk("R8 no load check", 32'(f1), 0);

    // R5 without snoop, and with snoop to another block
    do_reset();
    alloc(8'd10); alloc(8'd11);
    lexec(3'd1, 32'h240);
    lexec(3'd0, 32'h244);
    chk("R5 no snoop", 32'(f0), 0);
    do_reset();
    alloc(8'd10); alloc(8'd11);
    lexec(3'd1, 32'h240);
    snoop(32'h280);
    lexec(3'd0, 32'h244);
    chk("R5 other block", 32'(f0), 0);

    // R6 oldest of several; younger later violation does not replace
    do_reset();
    for (int k = 0; k < 4; k++) alloc(8'(20 + k));
    for (int k = 0; k < 4; k++) lexec(3'(k), 32'h300);
    store(8'd19, 32'h300);
    chk("R6 oldest idx", 32'(i0), 0);
    chk("R6 oldest tag", 32'(t0), 20);
    chk("R8 store side kept", 32'(f1), 1);
    store(8'd21, 32'h300);
    chk("R6 kept tag", 32'(t0), 20);
    cyc();
    chk("R7 sticky", 32'(f0), 1);
    viol_rd = 1; cyc();
    chk("R7 read clears", 32'(f0), 0);
    store(8'd21, 32'h300);
    chk("R6 new after read", 32'(t0), 22);
    viol_rd = 1;
    store(8'd19, 32'h300);
    chk("R7 read plus new flag", 32'(f0), 1);
    chk("R7 read plus new tag", 32'(t0), 20);

    // R10 squash
    do_reset();
    alloc(8'd30); alloc(8'd31); alloc(8'd32);
    for (int k = 0; k < 3; k++) lexec(3'(k), 32'h400);
    squash_vld = 1; squash_tag = 8'd30; cyc();
    store(8'd30, 32'h400);
    chk("R10 squashed excluded", 32'(f0), 0);
    store(8'd29, 32'h400);
    chk("R10 boundary kept idx", 32'(i0), 0);
    chk("R10 boundary kept tag", 32'(t0), 30);

    // R11 retire and index wrap
    do_reset();
    for (int k = 0; k < 6; k++) alloc(8'(40 + k));
    for (int k = 0; k < 6; k++) begin retire_vld = 1; cyc(); end
    for (int k = 0; k < 4; k++) alloc(8'(46 + k));
    lexec(3'd1, 32'h500);
    store(8'd45, 32'h500);
    chk("R11 wrapped idx", 32'(i0), 1);
    chk("R11 wrapped tag", 32'(t0), 49);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule